// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block derives the two timing strobes a UART needs from the system clock: a sample strobe at the oversampling rate and a bit strobe at the serial bit rate. A 16-bit integer divisor sets the base interval between sample strobes. A fractional stage then stretches selected intervals so that the average spacing becomes the divisor scaled by 1 + A/M. Here A is a 4-bit add field and M is a 4-bit multiplier field plus one.

The fractional stage keeps a remainder that runs modulo M. At every sample strobe it adds A to that remainder. When the sum reaches M, the remainder wraps and the next sample interval takes two integer intervals instead of one. A mode input picks 16 or 8 sample strobes per bit. When infrared pulse encoding is active, 8x oversampling cannot be used, so the block falls back to 16x and raises an error flag. An add field that is not smaller than M is also flagged and treated as zero.

The configuration inputs are expected to be static while the block runs. Any change to them restarts all counting. Dropping the enable restarts counting in the same way, and so does a divisor of zero.

Top module: `uart_frac_baudgen`

## Requirements
- R1: With an effective add value of zero, the n-th sample_tick after a restart occurs in cycle n*div_int (cycle 1 is the first counting cycle), whatever frac_mul holds.
- R2: With M = frac_mul+1 and an effective add value A (1..M-1), the n-th sample_tick after a restart occurs in cycle div_int*(n + floor((n-1)*A/M)).
- R3: When osr_8x=0, or when irda_mode=1, bit_tick is high together with every 16th sample_tick (the 16th, 32nd, ...) and at no other time.
- R4: When osr_8x=1 and irda_mode=0, bit_tick is high together with every 8th sample_tick and at no other time.
- R5: When osr_8x=1 and irda_mode=1, config_error is 1 and the bit timing follows R3.
- R6: When frac_add >= frac_mul+1, config_error is 1 and the sample timing follows R1. In all other legal cases with osr_8x=0 or irda_mode=0, config_error is 0.
- R7: When div_int is 0, sample_tick and bit_tick stay 0.
- R8: In the cycle in which any configuration input differs from its value in the previous cycle, both ticks are 0. The next cycle is cycle 1 of a new count.
- R9: While en is 0, both ticks are 0. The first cycle with en=1 is cycle 1 of a new count.
- R10: While rst is 1, both ticks are 0. The first cycle after rst falls is cycle 1 of a count. config_error follows its inputs even during reset.
- R11: bit_tick is never high without sample_tick. When div_int >= 2, sample_tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds all counters at zero |
| div_int | input | 16 | Integer divisor; 0 stops all ticks |
| frac_mul | input | 4 | Fractional multiplier field; modulus is this value plus one |
| frac_add | input | 4 | Fractional add field; extra intervals per modulus |
| osr_8x | input | 1 | 1 selects 8 sample ticks per bit, 0 selects 16 |
| irda_mode | input | 1 | Infrared encoding active; forces 16x oversampling |
| sample_tick | output | 1 | One-cycle strobe at the oversampling rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate, coincident with a sample tick |
| config_error | output | 1 | Illegal fractional or oversampling setting present |

## Verification
The bench builds the block with its default widths, a 16-bit divisor and 4-bit fractional fields. It then sweeps every combination of multiplier, add value and oversampling mode for divisors 1, 2 and 3. These small divisors keep each interval short, so every remainder sequence and every wrap pattern fits in a few dozen cycles. Together they reach all illegal add settings and every 8x and 16x bit boundary. Longer runs, infrared combinations and changes to the configuration in the middle of a run cover the restart and fallback rules.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    // Field widths of the generator configuration
    localparam int DIV_W      = 16;
    localparam int FRAC_W     = 4;
    localparam int MOD_W      = FRAC_W + 1;

    // Oversampling ratios and the sample counter width derived from them
    localparam int OSR_SLOW   = 16;
    localparam int OSR_FAST   = 8;
    localparam int OSR_CNT_W  = $clog2(OSR_SLOW);

    typedef logic [DIV_W-1:0]     div_t;
    typedef logic [FRAC_W-1:0]    frac_t;
    typedef logic [MOD_W-1:0]     mod_t;
    typedef logic [OSR_CNT_W-1:0] osr_cnt_t;

    // Configuration exactly as presented on the ports
    typedef struct packed {
        div_t  divisor;
        frac_t mul;
        frac_t add;
        logic  fast_osr;
        logic  irda;
    } cfg_raw_t;

    // Configuration after legality resolution
    typedef struct packed {
        div_t  divisor;
        mod_t  modulus;
        frac_t step;
        logic  fast_osr;
    } cfg_eff_t;

    // What the fractional stage does at the end of an integer interval
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_ADVANCE = 2'd1,
        ACC_WRAP    = 2'd2,
        ACC_STALL   = 2'd3
    } acc_op_e;

    function automatic mod_t modulus_of(input frac_t mul);
        return mod_t'(mul) + mod_t'(1);
    endfunction

    function automatic logic add_illegal(input frac_t add, input mod_t modulus);
        return mod_t'(add) >= modulus;
    endfunction

    function automatic osr_cnt_t last_sample(input logic fast_osr);
        return fast_osr ? osr_cnt_t'(OSR_FAST - 1) : osr_cnt_t'(OSR_SLOW - 1);
    endfunction

endpackage

// File: rtl/fbg_cfg_check.sv
module fbg_cfg_check
    import fbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_raw_t raw,
    output cfg_eff_t eff,
    output logic     config_error
);

    logic  osr_conflict;
    logic  add_bad;
    mod_t  modulus;

    always_comb begin
        modulus      = modulus_of(raw.mul);
        add_bad      = add_illegal(raw.add, modulus);
        osr_conflict = raw.fast_osr & raw.irda;

        eff.divisor  = raw.divisor;
        eff.modulus  = modulus;
        eff.step     = add_bad ? '0 : raw.add;
        eff.fast_osr = raw.fast_osr & ~raw.irda;

        config_error = osr_conflict | add_bad;
    end

    // The resolved step must always sit strictly below the modulus (R6)
    assert_step_legal_R6: assert property (@(posedge clk) disable iff (rst)
        mod_t'(eff.step) < eff.modulus);

    // Infrared mode can never yield the fast oversampling ratio (R5)
    assert_irda_slow_R5: assert property (@(posedge clk) disable iff (rst)
        raw.irda |-> !eff.fast_osr);

endmodule

// File: rtl/fbg_int_div.sv
module fbg_int_div
    import fbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  div_t divisor,
    output logic interval_done
);

    div_t cnt_q;
    div_t cnt_d;
    div_t last;

    always_comb begin
        last          = divisor - div_t'(1);
        interval_done = ~restart & (cnt_q == last);
        if (restart)
            cnt_d = '0;
        else if (interval_done)
            cnt_d = '0;
        else
            cnt_d = cnt_q + div_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // While running, the count stays inside the programmed interval (R1)
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        (!restart && divisor != '0) |-> (cnt_q <= last));

endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc
    import fbg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  restart,
    input  logic  interval_done,
    input  frac_t step,
    input  mod_t  modulus,
    output logic  sample_tick
);

    mod_t    acc_q;
    mod_t    acc_d;
    logic    stall_q;
    logic    stall_d;
    mod_t    sum;
    acc_op_e op;

    always_comb begin
        sum = acc_q + mod_t'(step);
        if (!interval_done)
            op = ACC_IDLE;
        else if (stall_q)
            op = ACC_STALL;
        else if (sum >= modulus)
            op = ACC_WRAP;
        else
            op = ACC_ADVANCE;

        sample_tick = (op == ACC_ADVANCE) | (op == ACC_WRAP);

        acc_d   = acc_q;
        stall_d = stall_q;
        unique case (op)
            ACC_IDLE:    ;
            ACC_STALL:   stall_d = 1'b0;
            ACC_ADVANCE: acc_d   = sum;
            ACC_WRAP: begin
                acc_d   = sum - modulus;
                stall_d = 1'b1;
            end
            default:     ;
        endcase
        if (restart) begin
            acc_d   = '0;
            stall_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            stall_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            stall_q <= stall_d;
        end
    end

    // The remainder never reaches the modulus while counting (R2)
    assert_acc_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (acc_q < modulus));

    // A zero step never produces a stretched interval (R1)
    assert_no_stretch_R1: assert property (@(posedge clk) disable iff (rst)
        (step == '0 && !restart) |-> !stall_q);

endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div
    import fbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic sample_tick,
    input  logic fast_osr,
    output logic bit_tick
);

    osr_cnt_t scnt_q;
    osr_cnt_t scnt_d;
    osr_cnt_t last;

    always_comb begin
        last     = last_sample(fast_osr);
        bit_tick = sample_tick & (scnt_q == last);
        if (restart)
            scnt_d = '0;
        else if (bit_tick)
            scnt_d = '0;
        else if (sample_tick)
            scnt_d = scnt_q + osr_cnt_t'(1);
        else
            scnt_d = scnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            scnt_q <= '0;
        else
            scnt_q <= scnt_d;
    end

    // The sample count never passes the selected ratio (R3, R4)
    assert_scnt_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (scnt_q <= last));

endmodule

// File: rtl/uart_frac_baudgen.sv
module uart_frac_baudgen
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] frac_mul,
    input  logic [FRAC_W-1:0] frac_add,
    input  logic              osr_8x,
    input  logic              irda_mode,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              config_error
);

    cfg_raw_t raw_now;
    cfg_raw_t raw_q;
    cfg_eff_t eff;
    logic     cfg_moved;
    logic     restart;
    logic     interval_done;

    always_comb begin
        raw_now.divisor  = div_int;
        raw_now.mul      = frac_mul;
        raw_now.add      = frac_add;
        raw_now.fast_osr = osr_8x;
        raw_now.irda     = irda_mode;
    end

    // Previous-cycle copy of the configuration; loaded during reset too,
    // so counting begins at once when reset falls
    always_ff @(posedge clk) begin
        raw_q <= raw_now;
    end

    always_comb begin
        cfg_moved = (raw_now != raw_q);
        restart   = rst | ~en | (div_int == '0) | cfg_moved;
    end

    fbg_cfg_check u_cfg (
        .clk          (clk),
        .rst          (rst),
        .raw          (raw_now),
        .eff          (eff),
        .config_error (config_error)
    );

    fbg_int_div u_div (
        .clk           (clk),
        .rst           (rst),
        .restart       (restart),
        .divisor       (eff.divisor),
        .interval_done (interval_done)
    );

    fbg_frac_acc u_acc (
        .clk           (clk),
        .rst           (rst),
        .restart       (restart),
        .interval_done (interval_done),
        .step          (eff.step),
        .modulus       (eff.modulus),
        .sample_tick   (sample_tick)
    );

    fbg_bit_div u_bit (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .sample_tick (sample_tick),
        .fast_osr    (eff.fast_osr),
        .bit_tick    (bit_tick)
    );

    assert_bit_needs_sample_R11: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    assert_pulse_width_R11: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && div_int > 16'd1) |=> !sample_tick);

    assert_zero_div_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (div_int == '0) |-> (!sample_tick && !bit_tick));

    assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!sample_tick && !bit_tick));

    assert_change_silent_R8: assert property (@(posedge clk) disable iff (rst)
        ({div_int, frac_mul, frac_add, osr_8x, irda_mode} !=
         $past({div_int, frac_mul, frac_add, osr_8x, irda_mode})) |-> !sample_tick);

    assert_irda_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (osr_8x && irda_mode) |-> config_error);

endmodule

// File: tb/uart_frac_baudgen_bench.sv
module uart_frac_baudgen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] div_int = 16'd0;
    logic [3:0]  frac_mul = 4'd0;
    logic [3:0]  frac_add = 4'd0;
    logic        osr_8x = 1'b0;
    logic        irda_mode = 1'b0;
    logic        sample_tick;
    logic        bit_tick;
    logic        config_error;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    uart_frac_baudgen u_uart_frac_baudgen (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .div_int      (div_int),
        .frac_mul     (frac_mul),
        .frac_add     (frac_add),
        .osr_8x       (osr_8x),
        .irda_mode    (irda_mode),
        .sample_tick  (sample_tick),
        .bit_tick     (bit_tick),
        .config_error (config_error)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycles);
            finish_run();
        end
    end

    task automatic check1(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int dv, input int m, input int a, input int o8, input int ir);
        div_int   = 16'(dv);
        frac_mul  = 4'(m);
        frac_add  = 4'(a);
        osr_8x    = 1'(o8);
        irda_mode = 1'(ir);
    endtask

    // Checks len counting cycles starting in the current cycle (cycle 1).
    // Tick n is expected at cycle dv*(n + floor((n-1)*A/M)) (R1, R2);
    // a bit tick accompanies tick n when n is a multiple of 8 or 16 (R3, R4).
    task automatic check_seq(input int dv, input int m, input int a, input int o8,
                             input int ir, input int len, input string tag);
        int modv     = m + 1;
        int aeff     = (a >= modv) ? 0 : a;
        int ratio    = (o8 != 0 && ir == 0) ? 8 : 16;
        int exp_err  = ((o8 != 0 && ir != 0) || a >= modv) ? 1 : 0;
        int n        = 1;
        int bad      = 0;
        int bad_c    = 0;
        int bad_act  = 0;
        int bad_exp  = 0;
        #1;
        check1({tag, " config_error R5/R6"}, int'(config_error), exp_err);
        for (int c = 1; c <= len; c++) begin
            int t_next = dv * (n + ((n - 1) * aeff) / modv);
            int e_s    = (c == t_next) ? 1 : 0;
            int e_b    = (e_s == 1 && (n % ratio) == 0) ? 1 : 0;
            int act    = {30'd0, sample_tick, bit_tick};
            int exp    = e_s * 2 + e_b;
            if (e_s == 1) n++;
            if (act != exp && bad == 0) begin
                bad_c = c; bad_act = act; bad_exp = exp;
            end
            if (act != exp) bad++;
            @(negedge clk);
            #1;
        end
        n_checks++;
        if (bad != 0) begin
            n_fails++;
            $display("FAIL %s R1/R2/R3/R4 dv=%0d m=%0d a=%0d o8=%0d ir=%0d cycle %0d: actual {sample,bit}=%0d expected=%0d",
                     tag, dv, m, a, o8, ir, bad_c, bad_act, bad_exp);
        end
    endtask

    // Start a count by raising the enable after a quiet setup (R9)
    task automatic run_en(input int dv, input int m, input int a, input int o8,
                          input int ir, input int len, input string tag);
        @(negedge clk);
        en = 1'b0;
        set_cfg(dv, m, a, o8, ir);
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        check_seq(dv, m, a, o8, ir, len, tag);
    endtask

    // Start a count by changing the configuration while enabled (R8)
    task automatic run_change(input int dv, input int m, input int a, input int o8,
                              input int ir, input int len, input string tag);
        @(negedge clk);
        set_cfg(dv, m, a, o8, ir);
        #1;
        check1({tag, " change cycle silent R8"}, int'({sample_tick, bit_tick}), 0);
        @(negedge clk);
        check_seq(dv, m, a, o8, ir, len, tag);
    endtask

    initial begin
        // R10: reset holds ticks low even with a one-cycle divisor
        en = 1'b1;
        set_cfg(1, 0, 0, 1, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            check1("reset ticks R10", int'({sample_tick, bit_tick}), 0);
        end
        check1("reset config_error follows inputs R10", int'(config_error), 1);
        set_cfg(2, 0, 0, 1, 0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_seq(2, 0, 0, 1, 0, 40, "after reset R10");

        // Sweep: every multiplier, add value and ratio for small divisors
        for (int dv = 1; dv <= 3; dv++)
            for (int m = 0; m < 16; m++)
                for (int a = 0; a < 16; a++)
                    for (int o8 = 0; o8 < 2; o8++)
                        run_en(dv, m, a, o8, 0, 40, "sweep");

        // Long fractional runs reaching many bit boundaries (R2, R3, R4)
        run_en(2, 4, 3, 0, 0, 400, "long 16x R2/R3");
        run_en(5, 9, 7, 1, 0, 300, "long 8x R2/R4");
        run_en(3, 15, 15, 0, 0, 600, "long max add R2");

        // Infrared forces 16x and flags the 8x request (R5)
        for (int m = 0; m < 16; m += 5)
            for (int a = 0; a < 3; a++) begin
                run_en(1, m, a, 1, 1, 70, "irda 8x R5");
                run_en(1, m, a, 0, 1, 40, "irda 16x R5");
            end

        // R7: a zero divisor keeps both ticks low
        @(negedge clk);
        en = 1'b1;
        set_cfg(0, 3, 1, 1, 0);
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            #1;
            check1("zero divisor R7", int'({sample_tick, bit_tick}), 0);
        end

        // R9: enable low silences output; re-enable counts from cycle 1
        run_en(3, 2, 1, 1, 0, 20, "pre-hold R9");
        @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 25; k++) begin
            #1;
            check1("enable low R9", int'({sample_tick, bit_tick}), 0);
            @(negedge clk);
        end
        en = 1'b1;
        check_seq(3, 2, 1, 1, 0, 80, "re-enable R9");

        // R8: configuration changes mid-run restart the count
        run_en(2, 6, 2, 0, 0, 37, "pre-change R8");
        run_change(2, 6, 3, 0, 0, 60, "add change R8");
        run_change(3, 6, 3, 0, 0, 60, "div change R8");
        run_change(3, 6, 3, 1, 0, 60, "osr change R8");
        run_change(3, 2, 3, 1, 0, 60, "to illegal add R8/R6");

        finish_run();
    end

endmodule